// File: doc/BRIEF.md
# Modem Transmit Character Serializer

This block turns bytes handed over by a host into the single serial bit stream that feeds a modem transmitter. A bit-rate enable strobe paces the output: each strobe ends the current bit and puts the next one on the line. A single-entry holding register sits in front of a frame shifter, so the host can queue the next byte while the current character is still going out. A ready flag and an underflow flag report the state of that buffer to a status block.

Two framing families are supported. In start-stop mode each character gets a start bit, 5 to 8 data bits sent least significant bit first, an optional odd or even parity bit and one or two stop bits. When no byte is waiting, the line rests at mark. In synchronous mode the block either sends raw 8-bit bytes and repeats the last byte when the host falls behind, or it sends one of several fixed test patterns and leaves the holding register untouched.

There are two write strobes for the same data port. The normal strobe queues a byte as configured. The alternate strobe queues a byte that, in start-stop mode, goes out with one stop bit fewer than configured. This lets a rate-adaptation layer shorten characters.

Top module: `modem_tx_serializer`

## Requirements
- R1: During and straight after reset, `tx_bit` is 1, `tx_ready` is 1 and `tx_underflow` is 0. The register that holds the last synchronous byte is cleared.
- R2: In start-stop mode, `cfg_shape` sets the character size. Data bits = 5 + `cfg_shape[2:1]` and stop bits = 1 + `cfg_shape[0]`: 000=5/1, 001=5/2, 010=6/1, 011=6/2, 100=7/1, 101=7/2, 110=8/1, 111=8/2.
- R3: `cfg_framing` selects the framing: 00 start-stop with odd parity, 01 start-stop with even parity, 10 start-stop without parity, 11 synchronous. With odd parity the data bits plus the parity bit hold an odd number of ones; with even parity they hold an even number.
- R4: Data goes out least significant bit first. In start-stop mode, byte bits at or above the configured data length have no effect on the line.
- R5: A start-stop character is a 0 start bit, then the data, then the parity bit if enabled, then the stop bits at 1. Each bit lasts exactly one `bit_en` period, and `tx_bit` changes only in the cycle after a `bit_en` strobe. A byte waiting in the holding register starts at the strobe that ends the previous character's last bit.
- R6: `tx_ready` is 1 while the holding register is empty. A write on either strobe fills it and clears `tx_ready` on the next cycle. Moving the byte into the shifter sets `tx_ready` again.
- R7: In start-stop mode, a character boundary with an empty holding register sets `tx_underflow` and puts a 1 on the line for that bit period. Any data write clears `tx_underflow`.
- R8: In synchronous mode with `cfg_shape[2]`=1, every byte goes out as exactly 8 bits with no start, parity or stop bits. At a boundary with an empty holding register, the last loaded byte is sent again and `tx_underflow` is set.
- R9: In synchronous mode with `cfg_shape[2]`=0, the line carries a test pattern: 000 inverts the line every bit, 010 sends continuous 0s, 011 and 001 send continuous 1s. The holding register is neither read nor changed in these modes.
- R10: A byte written with `wr_alt` in start-stop mode goes out with one stop bit fewer than configured (a 1-stop setting gives none). In synchronous mode it is sent exactly like a normal write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate strobe, one cycle per bit period |
| wr_norm | input | 1 | Write strobe, normal data address |
| wr_alt | input | 1 | Write strobe, reduced-stop data address |
| wr_data | input | 8 | Byte to queue |
| cfg_shape | input | 3 | Length/stop code (start-stop) or data source (synchronous) |
| cfg_framing | input | 2 | Framing and parity select |
| tx_bit | output | 1 | Serial output line |
| tx_ready | output | 1 | Holding register empty |
| tx_underflow | output | 1 | Shifter found no byte at a boundary |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- **Back-to-back characters.** A shifter that wastes a strobe between characters would insert a spurious mark bit.
- **Upper byte bits beyond a 5-bit length.** If these leaked into the frame, they would displace the parity and stop bits.
- **The alternate address with a 1-stop setting.** This must give a character with no stop bit at all; an off-by-one would leave a stop bit in place or eat a data bit.
- **Synchronous underflow.** A design that sends marks here instead of repeating the last byte would fail.
- **Pattern modes entered with a byte already queued.** The byte must stay put and go out intact once byte mode returns. A design that drained the buffer would lose it.

// File: rtl/modem_tx_pkg.sv
package modem_tx_pkg;

    typedef enum logic [1:0] {
        FR_ODD   = 2'b00,
        FR_EVEN  = 2'b01,
        FR_PLAIN = 2'b10,
        FR_SYNC  = 2'b11
    } framing_e;

    typedef enum logic [1:0] {
        PAT_FLIP = 2'b00,
        PAT_MARK = 2'b01,
        PAT_ZERO = 2'b10,
        PAT_ONES = 2'b11
    } pattern_e;

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_norm,
    input  logic              wr_alt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              full,
    output logic              hold_alt,
    output logic [DATA_W-1:0] hold_data
);

    typedef struct packed {
        logic              full;
        logic              alt;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hb_d, hb_q;
    logic  any_wr;

    assign any_wr = wr_norm | wr_alt;

    always_comb begin
        hb_d = hb_q;
        if (pop) begin
            hb_d.full = 1'b0;
        end
        if (any_wr) begin
            hb_d.full = 1'b1;
            hb_d.alt  = wr_alt & ~wr_norm;
            hb_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q <= '0;
        end else begin
            hb_q <= hb_d;
        end
    end

    assign full      = hb_q.full;
    assign hold_alt  = hb_q.alt;
    assign hold_data = hb_q.data;

    // R6
    fill_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> full);

    // R6
    empty_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !any_wr) |=> !full);

endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
    import modem_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               alt,
    input  logic [2:0]         shape,
    input  logic [1:0]         framing,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   frame_len
);

    localparam int MIN_DATA = DATA_W - 3;

    logic [CNT_W-1:0]  n_data;
    logic [CNT_W-1:0]  n_stop;
    logic              par_en;
    logic              par_bit;
    logic [DATA_W-1:0] masked;

    assign n_data = CNT_W'(MIN_DATA) + CNT_W'(shape[2:1]);
    assign n_stop = CNT_W'(1) + CNT_W'(shape[0]) - CNT_W'(alt);
    assign par_en = (framing != FR_PLAIN);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign masked[gi] = (CNT_W'(gi) < n_data) ? data[gi] : 1'b0;
    end

    assign par_bit = (framing == FR_EVEN) ? (^masked) : ~(^masked);

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < n_data) begin
                frame[i+1] = masked[i];
            end
        end
        if (par_en) begin
            frame[int'(n_data) + 1] = par_bit;
        end
    end

    assign frame_len = CNT_W'(1) + n_data + CNT_W'(par_en) + n_stop;

endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
    import modem_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               any_wr,
    input  logic [2:0]         shape,
    input  logic [1:0]         framing,
    input  logic               buf_full,
    input  logic [DATA_W-1:0]  buf_data,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   frame_len,
    output logic               pop,
    output logic               tx_bit,
    output logic               underflow
);

    typedef struct packed {
        logic               tx_bit;
        logic               underflow;
        logic [CNT_W-1:0]   rem;
        logic [FRAME_W-1:0] shreg;
        logic [DATA_W-1:0]  last;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   uf_set;
    logic   is_sync;
    logic   boundary;
    logic [DATA_W-1:0] sync_byte;

    assign is_sync  = (framing == FR_SYNC);
    assign boundary = (sh_q.rem == '0);

    always_comb begin
        sh_d      = sh_q;
        pop       = 1'b0;
        uf_set    = 1'b0;
        sync_byte = sh_q.last;
        if (bit_en) begin
            if (!boundary) begin
                sh_d.tx_bit = sh_q.shreg[0];
                sh_d.shreg  = {1'b1, sh_q.shreg[FRAME_W-1:1]};
                sh_d.rem    = sh_q.rem - CNT_W'(1);
            end else if (is_sync) begin
                if (shape[2]) begin
                    if (buf_full) begin
                        sync_byte = buf_data;
                        pop       = 1'b1;
                        sh_d.last = buf_data;
                    end else begin
                        uf_set = 1'b1;
                    end
                    sh_d.tx_bit = sync_byte[0];
                    sh_d.shreg  = {{(FRAME_W-DATA_W+1){1'b1}}, sync_byte[DATA_W-1:1]};
                    sh_d.rem    = CNT_W'(DATA_W - 1);
                end else begin
                    unique case (pattern_e'(shape[1:0]))
                        PAT_FLIP: sh_d.tx_bit = ~sh_q.tx_bit;
                        PAT_ZERO: sh_d.tx_bit = 1'b0;
                        PAT_ONES: sh_d.tx_bit = 1'b1;
                        default:  sh_d.tx_bit = 1'b1;
                    endcase
                end
            end else begin
                if (buf_full) begin
                    pop         = 1'b1;
                    sh_d.tx_bit = frame[0];
                    sh_d.shreg  = {1'b1, frame[FRAME_W-1:1]};
                    sh_d.rem    = frame_len - CNT_W'(1);
                end else begin
                    uf_set      = 1'b1;
                    sh_d.tx_bit = 1'b1;
                end
            end
        end
        if (any_wr) begin
            sh_d.underflow = 1'b0;
        end else if (uf_set) begin
            sh_d.underflow = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q        <= '0;
            sh_q.tx_bit <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_bit    = sh_q.tx_bit;
    assign underflow = sh_q.underflow;

    // R5
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R7
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && boundary && !is_sync && !buf_full) |=> tx_bit);

    // R7
    underflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !underflow);

    // R8
    sync_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && boundary && is_sync && shape[2] && !buf_full)
        |=> (tx_bit == $past(sh_q.last[0])));

    // R9
    zero_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && boundary && is_sync && shape == 3'b010) |=> !tx_bit);

endmodule

// File: rtl/modem_tx_serializer.sv
module modem_tx_serializer
    import modem_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              wr_norm,
    input  logic              wr_alt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        cfg_shape,
    input  logic [1:0]        cfg_framing,
    output logic              tx_bit,
    output logic              tx_ready,
    output logic              tx_underflow
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               buf_full;
    logic               buf_alt;
    logic [DATA_W-1:0]  buf_data;
    logic               pop;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;
    logic               any_wr;

    assign any_wr = wr_norm | wr_alt;

    tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_norm   (wr_norm),
        .wr_alt    (wr_alt),
        .wr_data   (wr_data),
        .pop       (pop),
        .full      (buf_full),
        .hold_alt  (buf_alt),
        .hold_data (buf_data)
    );

    tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .data      (buf_data),
        .alt       (buf_alt),
        .shape     (cfg_shape),
        .framing   (cfg_framing),
        .frame     (frame),
        .frame_len (frame_len)
    );

    tx_shift_engine #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .any_wr    (any_wr),
        .shape     (cfg_shape),
        .framing   (cfg_framing),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .frame     (frame),
        .frame_len (frame_len),
        .pop       (pop),
        .tx_bit    (tx_bit),
        .underflow (tx_underflow)
    );

    assign tx_ready = ~buf_full;

    // R6
    ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !tx_ready);

    // R9
    pattern_keeps_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cfg_framing == 2'b11 && !cfg_shape[2] && !tx_ready && !any_wr)
        |=> !tx_ready);

endmodule

// File: tb/tb_modem_tx_serializer.sv
`timescale 1ns/1ps
module tb_modem_tx_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_norm = 1'b0;
    logic       wr_alt = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] cfg_shape = '0;
    logic [1:0] cfg_framing = '0;
    logic       tx_bit;
    logic       tx_ready;
    logic       tx_underflow;

    modem_tx_serializer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .wr_norm      (wr_norm),
        .wr_alt       (wr_alt),
        .wr_data      (wr_data),
        .cfg_shape    (cfg_shape),
        .cfg_framing  (cfg_framing),
        .tx_bit       (tx_bit),
        .tx_ready     (tx_ready),
        .tx_underflow (tx_underflow)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic  q_bit[$];
    string q_tag[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic b, input string tag);
        q_bit.push_back(b);
        q_tag.push_back(tag);
    endtask

    // expected bit sequence for one character under the current configuration
    task automatic push_char(input logic [7:0] d, input bit alt, input string tag);
        int n;
        int st;
        int ones;
        n    = 5 + int'(cfg_shape[2:1]);
        st   = 1 + int'(cfg_shape[0]) - (alt ? 1 : 0);
        ones = 0;
        if (cfg_framing == 2'b11) begin
            for (int i = 0; i < 8; i++) push(d[i], tag);
        end else begin
            push(1'b0, tag);
            for (int i = 0; i < n; i++) begin
                push(d[i], tag);
                ones += int'(d[i]);
            end
            if (cfg_framing == 2'b00) push(((ones % 2) == 0) ? 1'b1 : 1'b0, tag);
            if (cfg_framing == 2'b01) push(((ones % 2) == 1) ? 1'b1 : 1'b0, tag);
            for (int s = 0; s < st; s++) push(1'b1, tag);
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input bit alt);
        @(negedge clk);
        wr_data = d;
        if (alt) wr_alt = 1'b1;
        else     wr_norm = 1'b1;
        @(negedge clk);
        wr_norm = 1'b0;
        wr_alt  = 1'b0;
    endtask

    task automatic tick(input int k);
        logic v;
        for (int j = 0; j < k; j++) begin
            @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            v = tx_bit;
            @(negedge clk);
            @(negedge clk);
            chk(tx_bit == v, "R5 line stable between strobes", int'(tx_bit), int'(v));
        end
    endtask

    // monitor: pops the scoreboard once per strobe
    always begin
        logic  en;
        logic  b;
        string t;
        @(posedge clk);
        en = bit_en;
        @(negedge clk);
        if (en && q_bit.size() > 0) begin
            b = q_bit.pop_front();
            t = q_tag.pop_front();
            chk(tx_bit == b, t, int'(tx_bit), int'(b));
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all R) actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b1, "R1 line in reset", int'(tx_bit), 1);
        chk(tx_ready == 1'b1, "R1 ready in reset", int'(tx_ready), 1);
        chk(tx_underflow == 1'b0, "R1 underflow in reset", int'(tx_underflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_bit == 1'b1 && tx_ready == 1'b1 && tx_underflow == 1'b0,
            "R1 state after reset", int'({tx_bit, tx_ready, tx_underflow}), 6);

        // 8 data, no parity, 1 stop: two back-to-back characters
        cfg_framing = 2'b10;
        cfg_shape   = 3'b110;
        write_byte(8'h5A, 1'b0);
        chk(tx_ready == 1'b0, "R6 ready cleared by write", int'(tx_ready), 0);
        push_char(8'h5A, 1'b0, "R5 8N1 first char");
        tick(1);
        chk(tx_ready == 1'b1, "R6 ready after load", int'(tx_ready), 1);
        write_byte(8'hC3, 1'b0);
        push_char(8'hC3, 1'b0, "R5 8N1 back-to-back char");
        tick(19);
        push(1'b1, "R7 idle mark on underflow");
        tick(1);
        chk(tx_underflow == 1'b1, "R7 underflow set", int'(tx_underflow), 1);
        chk(tx_ready == 1'b1, "R6 ready while empty", int'(tx_ready), 1);
        write_byte(8'h00, 1'b0);
        chk(tx_underflow == 1'b0, "R7 underflow cleared by write", int'(tx_underflow), 0);
        push_char(8'h00, 1'b0, "R2 8N1 zero byte");
        tick(10);

        // 5 data, odd parity, 2 stop; upper bits must not matter
        cfg_framing = 2'b00;
        cfg_shape   = 3'b001;
        write_byte(8'hF3, 1'b0);
        push_char(8'hF3, 1'b0, "R4 5O2 upper bits ignored");
        tick(1);
        write_byte(8'h13, 1'b0);
        push_char(8'h13, 1'b0, "R3 5O2 odd parity");
        tick(17);
        push(1'b1, "R7 idle mark");
        tick(1);

        // 7 data, even parity, 1 stop via alternate strobe: no stop bit
        cfg_framing = 2'b01;
        cfg_shape   = 3'b100;
        write_byte(8'h55, 1'b1);
        push_char(8'h55, 1'b1, "R10 alt drops only stop bit");
        tick(1);
        write_byte(8'h2A, 1'b1);
        push_char(8'h2A, 1'b1, "R3 even parity alt char");
        tick(17);
        push(1'b1, "R7 idle mark");
        tick(1);

        // 6 data, no parity, 2 stop via alternate strobe: one stop bit
        cfg_framing = 2'b10;
        cfg_shape   = 3'b011;
        write_byte(8'h3F, 1'b1);
        push_char(8'h3F, 1'b1, "R10 6N2 alt gives one stop");
        tick(8);
        push(1'b1, "R2 idle after 6-bit char");
        tick(1);

        // synchronous byte mode
        cfg_framing = 2'b11;
        cfg_shape   = 3'b100;
        write_byte(8'h3C, 1'b0);
        push_char(8'h3C, 1'b0, "R8 sync byte");
        tick(1);
        write_byte(8'h81, 1'b0);
        push_char(8'h81, 1'b0, "R8 sync second byte");
        tick(15);
        push_char(8'h81, 1'b0, "R8 sync repeat on underflow");
        tick(1);
        chk(tx_underflow == 1'b1, "R8 sync underflow set", int'(tx_underflow), 1);
        tick(7);
        write_byte(8'h0F, 1'b1);
        chk(tx_underflow == 1'b0, "R8 underflow cleared", int'(tx_underflow), 0);
        push_char(8'h0F, 1'b1, "R10 alt in sync sends 8 bits");
        tick(8);

        // pattern modes; last line bit was 0
        cfg_shape = 3'b000;
        for (int i = 0; i < 6; i++) push(((i % 2) == 0) ? 1'b1 : 1'b0, "R9 flip pattern");
        tick(2);
        write_byte(8'h99, 1'b0);
        tick(4);
        cfg_shape = 3'b010;
        for (int i = 0; i < 3; i++) push(1'b0, "R9 zero pattern");
        tick(3);
        cfg_shape = 3'b011;
        for (int i = 0; i < 3; i++) push(1'b1, "R9 ones pattern");
        tick(3);
        chk(tx_ready == 1'b0, "R9 buffer kept in pattern mode", int'(tx_ready), 0);
        cfg_shape = 3'b100;
        push_char(8'h99, 1'b0, "R9 held byte sent after patterns");
        tick(8);
        chk(tx_ready == 1'b1, "R6 ready after held byte", int'(tx_ready), 1);

        chk(q_bit.size() == 0, "R5 all expected bits seen", q_bit.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule